// File: doc/BRIEF.md
# Reserved Load and Conditional Store Unit

This block decodes and carries out the two 64-bit atomic instructions that form a reservation pair: a reserving load and a conditional store, each in a 4-byte word form and an 8-byte doubleword form. In one cycle it takes a 32-bit instruction word and the two source register values read from the register file. It drives a single memory request with address, size, write data and write enable, and a flag that marks the access as reserving or conditional. Read data returns in the same cycle. It also drives a register write-back port. Instructions that match the encoding but use an ordering-bit combination this unit does not handle are reported on a separate flag.

A single reservation register holds a valid bit, the reserved address and the access size. A reserving load sets it. A conditional store succeeds only against a matching reservation. Every handled conditional store clears the reservation, whether it succeeds or fails. The reservation updates on the clock edge that closes the cycle in which the instruction is presented. The memory request and the write-back are combinational in that cycle.

Top module: `lrsc_unit`

## Requirements
- R1: An instruction is recognised (`insn_hit`=1) only when bits [6:0] are 0101111, bits [14:12] are 010 (word) or 011 (doubleword), and bits [31:27] are 00010 (reserving load, which also needs bits [24:20] = 00000) or 00011 (conditional store). Any other word gives `insn_hit`=0, `mem_req`=0, `wb_en`=0 and `unsupported`=0.
- R2: A reserving load raises `mem_req`=1 with `mem_we`=0, `mem_addr` = rs1 value, `mem_resv`=1, `mem_aq` = bit 26, and `mem_size` = 2 for word or 3 for doubleword.
- R3: The word reserving load writes rd with bits [31:0] of `mem_rdata` sign-extended to 64 bits. The doubleword load writes all 64 bits of `mem_rdata` unchanged.
- R4: A conditional store succeeds only when the reservation is valid and its address and size both equal those of the store. On success it raises `mem_req`=1, `mem_we`=1, `mem_resv`=1, `mem_rl` = bit 25, and writes 0 to rd. `mem_we` is never 1 without `mem_req`.
- R5: On a successful store, `mem_wdata` is the rs2 value with bits [63:32] forced to zero for the word form, and the full rs2 value for the doubleword form.
- R6: A failing conditional store raises no memory request and writes 1 to rd.
- R7: A reserving load sets the reservation from its address and size. Any handled conditional store clears it, so a second store right after any store fails.
- R8: A reserving load with bit 25 set, or a conditional store with bit 26 set, gives `unsupported`=1, no memory request, no write-back, and leaves the reservation unchanged.
- R9: When rd (bits [11:7]) is 0 the write-back is suppressed (`wb_en`=0). The memory side and the reservation behave as for any other rd.
- R10: Reset clears the reservation valid bit, so the first conditional store after reset fails.
- R11: While `insn_valid`=0 there is no memory request, no write-back, no unsupported flag and no reservation change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| rs1_val | input | 64 | First source register value (address) |
| rs2_val | input | 64 | Second source register value (store data) |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 64 | Access address |
| mem_size | output | 2 | log2 of access bytes (2 or 3) |
| mem_wdata | output | 64 | Store data |
| mem_resv | output | 1 | Access is reserving or conditional |
| mem_aq | output | 1 | Acquire ordering bit forwarded |
| mem_rl | output | 1 | Release ordering bit forwarded |
| mem_rdata | input | 64 | Load data, valid in the request cycle |
| wb_en | output | 1 | Register write-back enable |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 64 | Write-back value |
| insn_hit | output | 1 | Instruction recognised by this unit |
| unsupported | output | 1 | Recognised but ordering bits not handled |

## Verification
The checker tests properties that hold in every cycle. A write never goes out without a request. A flagged or idle cycle stays silent. rd x0 is never written. A store result is always 0 or 1 and agrees with whether a write went out. The upper half of word-store data is zero. A store that directly follows another handled store always fails. Other behaviour depends on what the reservation holds after a particular sequence of instructions, and only the directed scenarios show it: a store succeeds after a matching load and fails on an address or size mismatch; a flagged instruction leaves an earlier reservation intact; reset leaves no reservation; sign extension uses the loaded value.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

   localparam logic [6:0] OPC_ATOMIC  = 7'b0101111;
   localparam logic [4:0] FN5_LOAD    = 5'b00010;
   localparam logic [4:0] FN5_STORE   = 5'b00011;
   localparam logic [2:0] WIDTH_WORD  = 3'b010;
   localparam logic [2:0] WIDTH_DWORD = 3'b011;
   localparam int         REG_IDX_W   = 5;

   typedef enum logic [1:0] {
      RSV_OP_NONE  = 2'd0,
      RSV_OP_LOAD  = 2'd1,
      RSV_OP_STORE = 2'd2
   } rsv_op_e;

   typedef struct packed {
      rsv_op_e                op;
      logic                   acq;
      logic                   rel;
      logic                   dword;
      logic                   bad_order;
      logic [REG_IDX_W-1:0]   rd;
   } rsv_dec_t;

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
   import lrsc_pkg::*;
(
   input  logic [31:0] insn,
   output rsv_dec_t    dec
);

   logic        opc_ok;
   logic        width_ok;
   logic        is_load;
   logic        is_store;
   logic        unused_src_idx;

   assign unused_src_idx = ^insn[19:15];

   assign opc_ok   = (insn[6:0] == OPC_ATOMIC);
   assign width_ok = (insn[14:12] == WIDTH_WORD) || (insn[14:12] == WIDTH_DWORD);
   assign is_load  = opc_ok && width_ok && (insn[31:27] == FN5_LOAD)
                     && (insn[24:20] == 5'b00000);
   assign is_store = opc_ok && width_ok && (insn[31:27] == FN5_STORE);

   always_comb begin
      dec       = '0;
      dec.acq   = insn[26];
      dec.rel   = insn[25];
      dec.dword = (insn[14:12] == WIDTH_DWORD);
      dec.rd    = insn[11:7];
      if (is_load) begin
         dec.op        = RSV_OP_LOAD;
         dec.bad_order = insn[25];
      end else if (is_store) begin
         dec.op        = RSV_OP_STORE;
         dec.bad_order = insn[26];
      end else begin
         dec.op        = RSV_OP_NONE;
         dec.bad_order = 1'b0;
      end
   end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
   parameter int ADDR_W     = 64,
   parameter bit MATCH_SIZE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic              clr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              dword_i,
   output logic              hit_o
);

   logic              held_vld;
   logic [ADDR_W-1:0] held_addr;
   logic              held_dword;
   logic              addr_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_vld   <= 1'b0;
         held_addr  <= '0;
         held_dword <= 1'b0;
      end else if (set_i) begin
         held_vld   <= 1'b1;
         held_addr  <= addr_i;
         held_dword <= dword_i;
      end else if (clr_i) begin
         held_vld   <= 1'b0;
      end
   end

   assign addr_eq = (held_addr == addr_i);

   generate
      if (MATCH_SIZE) begin : g_size_match
         assign hit_o = held_vld && addr_eq && (held_dword == dword_i);
      end else begin : g_addr_only
         logic unused_size;
         assign unused_size = held_dword ^ dword_i;
         assign hit_o = held_vld && addr_eq;
      end
   endgenerate

endmodule

// File: rtl/lrsc_exec.sv
module lrsc_exec
   import lrsc_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32
) (
   input  logic                 valid_i,
   input  rsv_dec_t             dec_i,
   input  logic [XLEN-1:0]      rs1_i,
   input  logic [XLEN-1:0]      rs2_i,
   input  logic [XLEN-1:0]      rdata_i,
   input  logic                 resv_hit_i,
   output logic                 load_go_o,
   output logic                 store_go_o,
   output logic                 mem_req_o,
   output logic                 mem_we_o,
   output logic [XLEN-1:0]      mem_addr_o,
   output logic [1:0]           mem_size_o,
   output logic [XLEN-1:0]      mem_wdata_o,
   output logic                 mem_resv_o,
   output logic                 mem_aq_o,
   output logic                 mem_rl_o,
   output logic                 wb_en_o,
   output logic [REG_IDX_W-1:0] wb_rd_o,
   output logic [XLEN-1:0]      wb_data_o
);

   localparam int HI_W = XLEN - WORD_W;

   logic            go;
   logic            store_ok;
   logic [XLEN-1:0] load_val;
   logic [XLEN-1:0] store_val;

   assign go         = valid_i && (dec_i.op != RSV_OP_NONE) && !dec_i.bad_order;
   assign load_go_o  = go && (dec_i.op == RSV_OP_LOAD);
   assign store_go_o = go && (dec_i.op == RSV_OP_STORE);
   assign store_ok   = store_go_o && resv_hit_i;

   assign load_val  = dec_i.dword ? rdata_i
                    : {{HI_W{rdata_i[WORD_W-1]}}, rdata_i[WORD_W-1:0]};
   assign store_val = dec_i.dword ? rs2_i
                    : {{HI_W{1'b0}}, rs2_i[WORD_W-1:0]};

   assign mem_req_o   = load_go_o || store_ok;
   assign mem_we_o    = store_ok;
   assign mem_addr_o  = rs1_i;
   assign mem_size_o  = dec_i.dword ? 2'd3 : 2'd2;
   assign mem_wdata_o = store_ok ? store_val : '0;
   assign mem_resv_o  = mem_req_o;
   assign mem_aq_o    = mem_req_o && dec_i.acq;
   assign mem_rl_o    = mem_req_o && dec_i.rel;

   assign wb_en_o = go && (dec_i.rd != '0);
   assign wb_rd_o = dec_i.rd;

   always_comb begin
      if (load_go_o)       wb_data_o = load_val;
      else if (store_ok)   wb_data_o = '0;
      else if (store_go_o) wb_data_o = {{(XLEN-1){1'b0}}, 1'b1};
      else                 wb_data_o = '0;
   end

endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
   import lrsc_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int WORD_W     = 32,
   parameter bit MATCH_SIZE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 insn_valid,
   input  logic [31:0]          insn,
   input  logic [XLEN-1:0]      rs1_val,
   input  logic [XLEN-1:0]      rs2_val,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [XLEN-1:0]      mem_addr,
   output logic [1:0]           mem_size,
   output logic [XLEN-1:0]      mem_wdata,
   output logic                 mem_resv,
   output logic                 mem_aq,
   output logic                 mem_rl,
   input  logic [XLEN-1:0]      mem_rdata,
   output logic                 wb_en,
   output logic [REG_IDX_W-1:0] wb_rd,
   output logic [XLEN-1:0]      wb_data,
   output logic                 insn_hit,
   output logic                 unsupported
);

   generate
      if (XLEN != 2 * WORD_W) begin : g_bad_width
         $error("lrsc_unit: XLEN must be twice WORD_W");
      end
      if (WORD_W < 8) begin : g_bad_word
         $error("lrsc_unit: WORD_W too small");
      end
   endgenerate

   rsv_dec_t dec;
   logic     resv_hit;
   logic     load_go;
   logic     store_go;

   lrsc_decode u_dec (
      .insn (insn),
      .dec  (dec)
   );

   lrsc_resv #(
      .ADDR_W     (XLEN),
      .MATCH_SIZE (MATCH_SIZE)
   ) u_resv (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (load_go),
      .clr_i   (store_go),
      .addr_i  (rs1_val),
      .dword_i (dec.dword),
      .hit_o   (resv_hit)
   );

   lrsc_exec #(
      .XLEN   (XLEN),
      .WORD_W (WORD_W)
   ) u_exec (
      .valid_i     (insn_valid),
      .dec_i       (dec),
      .rs1_i       (rs1_val),
      .rs2_i       (rs2_val),
      .rdata_i     (mem_rdata),
      .resv_hit_i  (resv_hit),
      .load_go_o   (load_go),
      .store_go_o  (store_go),
      .mem_req_o   (mem_req),
      .mem_we_o    (mem_we),
      .mem_addr_o  (mem_addr),
      .mem_size_o  (mem_size),
      .mem_wdata_o (mem_wdata),
      .mem_resv_o  (mem_resv),
      .mem_aq_o    (mem_aq),
      .mem_rl_o    (mem_rl),
      .wb_en_o     (wb_en),
      .wb_rd_o     (wb_rd),
      .wb_data_o   (wb_data)
   );

   assign insn_hit    = insn_valid && (dec.op != RSV_OP_NONE);
   assign unsupported = insn_hit && dec.bad_order;

endmodule

// File: rtl/lrsc_unit_chk.sv
module lrsc_unit_chk #(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              insn_valid,
   input logic              insn_hit,
   input logic              unsupported,
   input logic              is_store,
   input logic              is_word,
   input logic              mem_req,
   input logic              mem_we,
   input logic [XLEN-1:0]   mem_wdata,
   input logic              wb_en,
   input logic [4:0]        wb_rd,
   input logic [XLEN-1:0]   wb_data
);

   logic store_live;
   logic unused_low;
   assign store_live = insn_valid && insn_hit && !unsupported && is_store;
   assign unused_low = ^mem_wdata[WORD_W-1:0];

   AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);                                            // R4

   AST_FLAGGED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |-> (!mem_req && !wb_en));                           // R8

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |-> (!mem_req && !wb_en && !unsupported && !insn_hit)); // R11

   AST_NO_X0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_rd != 5'd0));                                      // R9

   AST_STORE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (store_live && wb_en) |-> (wb_data == (mem_req ? '0 : {{(XLEN-1){1'b0}}, 1'b1}))); // R6

   AST_WORD_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (store_live && is_word && mem_we) |-> (mem_wdata[XLEN-1:WORD_W] == '0)); // R5

   AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      store_live |=> !(store_live && mem_req));                        // R7

endmodule

bind lrsc_unit lrsc_unit_chk #(
   .XLEN   (XLEN),
   .WORD_W (WORD_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .insn_valid  (insn_valid),
   .insn_hit    (insn_hit),
   .unsupported (unsupported),
   .is_store    (insn[31:27] == 5'b00011),
   .is_word     (insn[14:12] == 3'b010),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_wdata   (mem_wdata),
   .wb_en       (wb_en),
   .wb_rd       (wb_rd),
   .wb_data     (wb_data)
);

// File: tb/lrsc_unit_tb_top.sv
module lrsc_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [31:0] insn = '0;
   logic [63:0] rs1_val = '0;
   logic [63:0] rs2_val = '0;
   logic [63:0] mem_rdata = '0;
   logic        mem_req, mem_we, mem_resv, mem_aq, mem_rl;
   logic [63:0] mem_addr, mem_wdata, wb_data;
   logic [1:0]  mem_size;
   logic        wb_en, insn_hit, unsupported;
   logic [4:0]  wb_rd;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   lrsc_unit dut_i (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
      .rs1_val(rs1_val), .rs2_val(rs2_val), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
      .mem_resv(mem_resv), .mem_aq(mem_aq), .mem_rl(mem_rl), .mem_rdata(mem_rdata),
      .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data), .insn_hit(insn_hit),
      .unsupported(unsupported)
   );

   function automatic logic [31:0] enc(input logic [4:0] f5, input logic aq,
                                       input logic rl, input logic [4:0] src2,
                                       input logic [2:0] f3, input logic [4:0] rd);
      return {f5, aq, rl, src2, 5'd10, f3, rd, 7'b0101111};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] w, input logic [63:0] a,
                        input logic [63:0] d, input logic [63:0] rd_data);
      @(negedge clk);
      insn_valid = 1'b1; insn = w; rs1_val = a; rs2_val = d; mem_rdata = rd_data;
      #1;
   endtask

   task automatic go_idle();
      @(negedge clk);
      insn_valid = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      check("R10", "idle req after reset", {63'd0, mem_req}, 64'd0);
      issue(enc(5'b00011, 0, 0, 5'd3, 3'b011, 5'd4), 64'h1000, 64'h55, 64'h0);
      check("R10", "store after reset req", {63'd0, mem_req}, 64'd0);
      check("R6", "failed store rd value", wb_data, 64'd1);
      check("R6", "failed store wb_en", {63'd0, wb_en}, 64'd1);
   endtask

   task automatic t_word_pair();
      issue(enc(5'b00010, 1, 0, 5'd0, 3'b010, 5'd5), 64'h2000, 64'h0, 64'hDEADBEEF_80000001);
      check("R2", "load req/we/resv/aq", {60'd0, mem_req, mem_we, mem_resv, mem_aq}, 64'hB);
      check("R2", "load addr", mem_addr, 64'h2000);
      check("R2", "load size word", {62'd0, mem_size}, 64'd2);
      check("R3", "word sign-extend", wb_data, 64'hFFFFFFFF_80000001);
      issue(enc(5'b00011, 0, 1, 5'd3, 3'b010, 5'd6), 64'h2000, 64'h11223344_55667788, 64'h0);
      check("R4", "store ok req/we/resv/rl", {60'd0, mem_req, mem_we, mem_resv, mem_rl}, 64'hF);
      check("R4", "store ok rd zero", wb_data, 64'd0);
      check("R5", "word store data", mem_wdata, 64'h00000000_55667788);
      issue(enc(5'b00011, 0, 0, 5'd3, 3'b010, 5'd6), 64'h2000, 64'h1, 64'h0);
      check("R7", "second store fails", {63'd0, mem_req}, 64'd0);
      check("R7", "second store rd one", wb_data, 64'd1);
      issue(enc(5'b00010, 0, 0, 5'd0, 3'b010, 5'd5), 64'h2100, 64'h0, 64'h0000_0000_7FFF_FFFF);
      check("R3", "word positive extend", wb_data, 64'h00000000_7FFFFFFF);
   endtask

   task automatic t_dword_pair();
      issue(enc(5'b00010, 0, 0, 5'd0, 3'b011, 5'd7), 64'h3000, 64'h0, 64'h81234567_89ABCDEF);
      check("R3", "dword unchanged", wb_data, 64'h81234567_89ABCDEF);
      check("R2", "load size dword", {62'd0, mem_size}, 64'd3);
      issue(enc(5'b00011, 0, 0, 5'd3, 3'b011, 5'd8), 64'h3008, 64'h9, 64'h0);
      check("R6", "addr mismatch no req", {63'd0, mem_req}, 64'd0);
      check("R6", "addr mismatch rd", wb_data, 64'd1);
      issue(enc(5'b00010, 0, 0, 5'd0, 3'b011, 5'd7), 64'h3000, 64'h0, 64'h0);
      issue(enc(5'b00011, 0, 0, 5'd3, 3'b010, 5'd8), 64'h3000, 64'h9, 64'h0);
      check("R4", "size mismatch fails", {63'd0, mem_req}, 64'd0);
      issue(enc(5'b00010, 0, 0, 5'd0, 3'b011, 5'd7), 64'h3000, 64'h0, 64'h0);
      issue(enc(5'b00011, 0, 0, 5'd3, 3'b011, 5'd8), 64'h3000, 64'hCAFEF00D_12345678, 64'h0);
      check("R4", "dword store ok we", {63'd0, mem_we}, 64'd1);
      check("R5", "dword store data", mem_wdata, 64'hCAFEF00D_12345678);
   endtask

   task automatic t_flagged();
      issue(enc(5'b00010, 0, 0, 5'd0, 3'b011, 5'd9), 64'h4000, 64'h0, 64'h0);
      issue(enc(5'b00011, 1, 0, 5'd3, 3'b011, 5'd9), 64'h4000, 64'h7, 64'h0);
      check("R8", "store aq flagged", {61'd0, unsupported, mem_req, wb_en}, 64'h4);
      issue(enc(5'b00011, 0, 0, 5'd3, 3'b011, 5'd9), 64'h4000, 64'h7, 64'h0);
      check("R8", "reservation kept", {63'd0, mem_we}, 64'd1);
      issue(enc(5'b00010, 0, 1, 5'd0, 3'b010, 5'd9), 64'h4400, 64'h0, 64'h5);
      check("R8", "load rl flagged", {61'd0, unsupported, mem_req, wb_en}, 64'h4);
      issue(enc(5'b00011, 0, 0, 5'd3, 3'b010, 5'd9), 64'h4400, 64'h7, 64'h0);
      check("R8", "flagged load set nothing", {63'd0, mem_req}, 64'd0);
   endtask

   task automatic t_decode();
      issue(enc(5'b00010, 0, 0, 5'd0, 3'b000, 5'd9), 64'h5000, 64'h0, 64'h0);
      check("R1", "bad width", {61'd0, insn_hit, mem_req, wb_en}, 64'd0);
      issue(enc(5'b00010, 0, 0, 5'd4, 3'b011, 5'd9), 64'h5000, 64'h0, 64'h0);
      check("R1", "load src2 nonzero", {61'd0, insn_hit, mem_req, wb_en}, 64'd0);
      issue(enc(5'b00001, 0, 0, 5'd3, 3'b011, 5'd9), 64'h5000, 64'h0, 64'h0);
      check("R1", "other funct5", {61'd0, insn_hit, mem_req, wb_en}, 64'd0);
      issue(enc(5'b00011, 1, 0, 5'd3, 3'b011, 5'd9) ^ 32'h1, 64'h5000, 64'h0, 64'h0);
      check("R1", "wrong opcode", {61'd0, insn_hit, unsupported, mem_req}, 64'd0);
      issue(enc(5'b00010, 0, 0, 5'd0, 3'b011, 5'd9), 64'h5000, 64'h0, 64'h0);
      check("R1", "load recognised", {63'd0, insn_hit}, 64'd1);
      @(negedge clk); insn_valid = 1'b0;
      insn = enc(5'b00010, 0, 0, 5'd0, 3'b011, 5'd9); #1;
      check("R11", "invalid quiet", {60'd0, insn_hit, mem_req, wb_en, unsupported}, 64'd0);
      issue(enc(5'b00011, 0, 0, 5'd3, 3'b011, 5'd9), 64'h5000, 64'h3, 64'h0);
      check("R11", "reservation survives idle", {63'd0, mem_we}, 64'd1);
   endtask

   task automatic t_x0();
      issue(enc(5'b00010, 0, 0, 5'd0, 3'b011, 5'd0), 64'h6000, 64'h0, 64'h1);
      check("R9", "load x0 no wb", {62'd0, wb_en, mem_req}, 64'd1);
      issue(enc(5'b00011, 0, 0, 5'd3, 3'b011, 5'd0), 64'h6000, 64'h2, 64'h0);
      check("R9", "store x0 writes mem only", {62'd0, wb_en, mem_we}, 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_word_pair();
      t_dword_pair();
      t_flagged();
      t_decode();
      t_x0();
      go_idle();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-R actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule